// File: doc/BRIEF.md
# Load/Store Effective Address Unit

This unit sits in the execute stage of a 32-bit processor pipeline. It takes one single-word or single-byte memory transfer instruction and works out where that transfer goes in memory. It also works out whether the base register must be updated, and with what value. The operands come from the register read stage: the instruction word, the base register value, the index register value, the address of the instruction itself and the current carry flag.

The offset has two possible sources. It can be a 12-bit unsigned constant held in the instruction. It can also be the index register, shifted by a constant amount. Three control bits in the instruction then choose the behaviour:

- whether the offset is added or subtracted;
- whether it is applied before the access (pre-indexed) or only to the updated base (post-indexed);
- whether a pre-indexed result is written back.

Register-specified shift amounts are not allowed for this kind of instruction, and the unit flags them. The load/store and byte/word bits are passed through to the memory stage. All outputs are registered, so results appear one clock after the operands are presented.

Top module: `lsag_top`

## Requirements
- R1: While `rst` is high at a clock edge, every output is cleared to zero at that edge.
- R2: Every output reflects the inputs that were present at the previous rising clock edge (one cycle of latency). With bit 25 clear, the offset is bits 11:0 zero-extended. With bit 23 set the offset is added to the base; with bit 23 clear it is subtracted.
- R3: With bit 24 clear (post-indexed), `mem_addr` equals the base. `wb_en` is 1, and `wb_data` equals the base plus or minus the offset.
- R4: With bits 24 and 21 both set (pre-indexed with update), `mem_addr` and `wb_data` both equal the base plus or minus the offset, and `wb_en` is 1.
- R5: With bit 24 set and bit 21 clear, `mem_addr` equals the base plus or minus the offset and `wb_en` is 0.
- R6: With bit 25 set and bit 4 clear, the offset is `idx_val` shifted by the amount in bits 11:7. The shift kind is given by bits 6:5: 00 is a left shift, 01 a logical right shift, 10 an arithmetic right shift and 11 a rotate right.
- R7: A shift amount of zero means the following for each kind. Left shift: `idx_val` unchanged. Logical right: zero. Arithmetic right: every bit equal to bit 31. Rotate: a one-bit right rotate through the carry, with `carry_in` entering bit 31.
- R8: With bits 25 and 4 both set, `bad_enc` is 1, `wb_en` is 0 and `mem_addr` equals the base. Otherwise `bad_enc` is 0.
- R9: When bits 19:16 equal 15, the base used is `pc_val` + 8, and `wb_en` is 0.
- R10: `is_load` copies bit 20 and `is_byte` copies bit 22.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 32 | Transfer instruction word |
| base_val | input | 32 | Value of the base register named by bits 19:16 |
| idx_val | input | 32 | Value of the index register named by bits 3:0 |
| pc_val | input | 32 | Address of the instruction |
| carry_in | input | 1 | Current carry flag |
| mem_addr | output | 32 | Effective access address |
| wb_en | output | 1 | Base register update enable |
| wb_data | output | 32 | New base register value |
| is_load | output | 1 | 1 for a load, 0 for a store |
| is_byte | output | 1 | 1 for a byte transfer, 0 for a word |
| bad_enc | output | 1 | Register-specified shift seen (invalid here) |

## Verification
The indexing modes are driven with constant offsets in both directions. Each case is chosen so that the address and the written-back value differ, which separates post-indexed, plain offset and pre-indexed-with-update behaviour.

Register offsets are run through each shift kind with both a nonzero amount and a zero amount. Negative operands are used so that a logical shift cannot be mistaken for an arithmetic one. The rotate-through-carry case is run with the carry both set and clear.

The invalid shift encoding, the program-counter base and the pass-through bits are each tried with values that would expose a leaked update or a wrong base.

// File: rtl/lsag_pkg.sv
package lsag_pkg;
  localparam int INSTR_W = 32;
  localparam int IMM_W   = 12;
  localparam int AMT_W   = 5;
  localparam int RIDX_W  = 4;

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shift_kind_t;

  typedef struct packed {
    logic              reg_off;
    logic              pre;
    logic              up;
    logic              byte_op;
    logic              wb_bit;
    logic              load;
    logic [RIDX_W-1:0] rn;
    logic [AMT_W-1:0]  sh_amt;
    shift_kind_t       sh_kind;
    logic              sh_by_reg;
    logic [IMM_W-1:0]  imm;
  } ls_fields_t;
endpackage

// File: rtl/lsag_decode.sv
module lsag_decode
  import lsag_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output ls_fields_t         fld
);
  logic unused_bits;
  assign unused_bits = ^{instr[31:26], instr[15:12], instr[3:0]};

  always_comb begin
    fld           = '0;
    fld.reg_off   = instr[25];
    fld.pre       = instr[24];
    fld.up        = instr[23];
    fld.byte_op   = instr[22];
    fld.wb_bit    = instr[21];
    fld.load      = instr[20];
    fld.rn        = instr[19:16];
    fld.sh_amt    = instr[11:7];
    fld.sh_kind   = shift_kind_t'(instr[6:5]);
    fld.sh_by_reg = instr[4];
    fld.imm       = instr[IMM_W-1:0];
  end
endmodule

// File: rtl/lsag_shift.sv
module lsag_shift
  import lsag_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] rm,
  input  shift_kind_t       kind,
  input  logic [AMT_W-1:0]  amt,
  input  logic              c_in,
  output logic [DATA_W-1:0] res
);
  localparam int DBL_W = 2 * DATA_W;

  logic [DBL_W-1:0]  dbl;
  logic [DBL_W-1:0]  rot_full;
  logic              amt_zero;

  assign dbl      = {rm, rm};
  assign rot_full = dbl >> amt;
  assign amt_zero = (amt == '0);

  always_comb begin
    unique case (kind)
      SH_LSL: res = rm << amt;
      SH_LSR: res = amt_zero ? '0 : (rm >> amt);
      SH_ASR: res = amt_zero ? {DATA_W{rm[DATA_W-1]}}
                             : DATA_W'($signed(rm) >>> amt);
      SH_ROR: res = amt_zero ? {c_in, rm[DATA_W-1:1]}
                             : rot_full[DATA_W-1:0];
      default: res = rm;
    endcase
  end
endmodule

// File: rtl/lsag_addr.sv
module lsag_addr #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] base,
  input  logic [DATA_W-1:0] offset,
  input  logic              up,
  input  logic              pre,
  input  logic              wb_bit,
  input  logic              base_is_pc,
  input  logic              bad,
  output logic [DATA_W-1:0] addr,
  output logic              wb_en,
  output logic [DATA_W-1:0] wb_val
);
  logic [DATA_W-1:0] moved;

  assign moved  = up ? (base + offset) : (base - offset);
  assign wb_val = moved;

  always_comb begin
    if (bad) begin
      addr  = base;
      wb_en = 1'b0;
    end else if (!pre) begin
      addr  = base;
      wb_en = !base_is_pc;
    end else begin
      addr  = moved;
      wb_en = wb_bit && !base_is_pc;
    end
  end
endmodule

// File: rtl/lsag_top.sv
module lsag_top
  import lsag_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int PC_AHEAD  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] instr,
  input  logic [DATA_W-1:0]  base_val,
  input  logic [DATA_W-1:0]  idx_val,
  input  logic [DATA_W-1:0]  pc_val,
  input  logic               carry_in,
  output logic [DATA_W-1:0]  mem_addr,
  output logic               wb_en,
  output logic [DATA_W-1:0]  wb_data,
  output logic               is_load,
  output logic               is_byte,
  output logic               bad_enc
);
  localparam logic [RIDX_W-1:0] PC_IDX = '1;

  ls_fields_t        fld;
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] offset;
  logic [DATA_W-1:0] base_eff;
  logic              base_is_pc;
  logic              bad;
  logic [DATA_W-1:0] addr_c;
  logic              wb_en_c;
  logic [DATA_W-1:0] wb_val_c;
  logic              primed;

  lsag_decode u_dec (.instr(instr), .fld(fld));

  lsag_shift #(.DATA_W(DATA_W)) u_shift (
    .rm(idx_val), .kind(fld.sh_kind), .amt(fld.sh_amt),
    .c_in(carry_in), .res(shifted)
  );

  generate
    if (DATA_W > IMM_W) begin : g_imm_pad
      assign imm_ext = {{(DATA_W-IMM_W){1'b0}}, fld.imm};
    end else begin : g_imm_cut
      assign imm_ext = fld.imm[DATA_W-1:0];
    end
  endgenerate

  assign offset     = fld.reg_off ? shifted : imm_ext;
  assign base_is_pc = (fld.rn == PC_IDX);
  assign base_eff   = base_is_pc ? (pc_val + DATA_W'(PC_AHEAD)) : base_val;
  assign bad        = fld.reg_off && fld.sh_by_reg;

  lsag_addr #(.DATA_W(DATA_W)) u_addr (
    .base(base_eff), .offset(offset), .up(fld.up), .pre(fld.pre),
    .wb_bit(fld.wb_bit), .base_is_pc(base_is_pc), .bad(bad),
    .addr(addr_c), .wb_en(wb_en_c), .wb_val(wb_val_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr <= '0;
      wb_en    <= 1'b0;
      wb_data  <= '0;
      is_load  <= 1'b0;
      is_byte  <= 1'b0;
      bad_enc  <= 1'b0;
      primed   <= 1'b0;
    end else begin
      mem_addr <= addr_c;
      wb_en    <= wb_en_c;
      wb_data  <= wb_val_c;
      is_load  <= fld.load;
      is_byte  <= fld.byte_op;
      bad_enc  <= bad;
      primed   <= 1'b1;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (mem_addr == '0 && !wb_en && !bad_enc));

  p_post_base_r3: assert property (@(posedge clk) disable iff (rst)
    primed && $past(!instr[24] && !instr[25] && instr[19:16] != 4'hF)
      |-> (mem_addr == $past(base_val) && wb_en));

  p_pre_same_r4: assert property (@(posedge clk) disable iff (rst)
    primed && wb_en && $past(instr[24]) |-> (mem_addr == wb_data));

  p_offset_nowb_r5: assert property (@(posedge clk) disable iff (rst)
    primed && $past(instr[24] && !instr[21]) |-> !wb_en);

  p_bad_flag_r8: assert property (@(posedge clk) disable iff (rst)
    primed && $past(instr[25] && instr[4]) |-> (bad_enc && !wb_en));

  p_pc_nowb_r9: assert property (@(posedge clk) disable iff (rst)
    primed && $past(instr[19:16] == 4'hF) |-> !wb_en);

  p_passthru_r10: assert property (@(posedge clk) disable iff (rst)
    primed |-> (is_load == $past(instr[20]) && is_byte == $past(instr[22])));
endmodule

// File: tb/test_lsag_top.sv
`timescale 1ns/1ps
module test_lsag_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] instr;
  logic [31:0] base_val;
  logic [31:0] idx_val;
  logic [31:0] pc_val;
  logic        carry_in;
  logic [31:0] mem_addr;
  logic        wb_en;
  logic [31:0] wb_data;
  logic        is_load;
  logic        is_byte;
  logic        bad_enc;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  lsag_top i_lsag_top (
    .clk(clk), .rst(rst), .instr(instr), .base_val(base_val),
    .idx_val(idx_val), .pc_val(pc_val), .carry_in(carry_in),
    .mem_addr(mem_addr), .wb_en(wb_en), .wb_data(wb_data),
    .is_load(is_load), .is_byte(is_byte), .bad_enc(bad_enc)
  );

  function automatic logic [31:0] enc(input bit i, input bit p, input bit u,
                                      input bit b, input bit w, input bit l,
                                      input logic [3:0] rn, input logic [11:0] low);
    return {4'hE, 2'b01, i, p, u, b, w, l, rn, 4'h3, low};
  endfunction

  function automatic logic [11:0] reg_low(input logic [4:0] amt, input logic [1:0] kind);
    return {amt, kind, 1'b0, 4'h2};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] ins, input logic [31:0] b,
                       input logic [31:0] x, input logic [31:0] pc, input bit c);
    @(negedge clk);
    instr = ins; base_val = b; idx_val = x; pc_val = pc; carry_in = c;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    instr = enc(0, 0, 1, 1, 0, 1, 4'h1, 12'h010);
    base_val = 32'h1000; idx_val = 0; pc_val = 0; carry_in = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1", "addr", mem_addr, 0);
    chk("R1", "flags", {wb_en, is_load, is_byte, bad_enc}, 0);
    rst = 1'b0;
  endtask

  task automatic t_post_imm;
    apply(enc(0, 0, 1, 0, 0, 1, 4'h2, 12'h123), 32'h0000_1000, 0, 0, 0);
    chk("R3", "post add addr", mem_addr, 32'h0000_1000);
    chk("R3", "post add wb_en", wb_en, 1);
    chk("R2", "post add wb_data", wb_data, 32'h0000_1123);
    apply(enc(0, 0, 0, 0, 0, 0, 4'h2, 12'hFFF), 32'h0000_0800, 0, 0, 0);
    chk("R3", "post sub addr", mem_addr, 32'h0000_0800);
    chk("R2", "post sub wb_data", wb_data, 32'h0000_0800 - 32'hFFF);
  endtask

  task automatic t_pre_modes;
    apply(enc(0, 1, 1, 0, 1, 0, 4'h4, 12'h040), 32'h2000_0000, 0, 0, 0);
    chk("R4", "pre wb addr", mem_addr, 32'h2000_0040);
    chk("R4", "pre wb data", wb_data, 32'h2000_0040);
    chk("R4", "pre wb en", wb_en, 1);
    apply(enc(0, 1, 0, 0, 0, 0, 4'h4, 12'h004), 32'h2000_0000, 0, 0, 0);
    chk("R5", "offset addr", mem_addr, 32'h1FFF_FFFC);
    chk("R5", "offset wb_en", wb_en, 0);
  endtask

  task automatic t_reg_shifts;
    apply(enc(1, 1, 1, 0, 0, 0, 4'h1, reg_low(5'd4, 2'b00)), 32'h100, 32'h0000_0003, 0, 0);
    chk("R6", "lsl 4", mem_addr, 32'h130);
    apply(enc(1, 1, 1, 0, 0, 0, 4'h1, reg_low(5'd8, 2'b01)), 32'h100, 32'h8000_1200, 0, 0);
    chk("R6", "lsr 8", mem_addr, 32'h100 + 32'h0080_0012);
    apply(enc(1, 1, 1, 0, 0, 0, 4'h1, reg_low(5'd4, 2'b10)), 32'h0, 32'hF000_0010, 0, 0);
    chk("R6", "asr 4", mem_addr, 32'hFF00_0001);
    apply(enc(1, 1, 1, 0, 0, 0, 4'h1, reg_low(5'd8, 2'b11)), 32'h0, 32'h1234_56AB, 0, 0);
    chk("R6", "ror 8", mem_addr, 32'hAB12_3456);
  endtask

  task automatic t_zero_amounts;
    apply(enc(1, 1, 1, 0, 0, 0, 4'h1, reg_low(5'd0, 2'b00)), 32'h10, 32'h0000_0005, 0, 0);
    chk("R7", "lsl 0", mem_addr, 32'h15);
    apply(enc(1, 1, 1, 0, 0, 0, 4'h1, reg_low(5'd0, 2'b01)), 32'h10, 32'hFFFF_FFFF, 0, 0);
    chk("R7", "lsr 32", mem_addr, 32'h10);
    apply(enc(1, 1, 0, 0, 0, 0, 4'h1, reg_low(5'd0, 2'b10)), 32'h10, 32'h8000_0000, 0, 0);
    chk("R7", "asr 32 neg", mem_addr, 32'h11);
    apply(enc(1, 1, 1, 0, 0, 0, 4'h1, reg_low(5'd0, 2'b11)), 32'h0, 32'h0000_0003, 0, 1);
    chk("R7", "rrx c=1", mem_addr, 32'h8000_0001);
    apply(enc(1, 1, 1, 0, 0, 0, 4'h1, reg_low(5'd0, 2'b11)), 32'h0, 32'h0000_0003, 0, 0);
    chk("R7", "rrx c=0", mem_addr, 32'h0000_0001);
  endtask

  task automatic t_bad_enc;
    apply(enc(1, 1, 1, 0, 1, 0, 4'h6, {5'd0, 2'b00, 1'b1, 4'h2}), 32'h5000, 32'h40, 0, 0);
    chk("R8", "bad flag", bad_enc, 1);
    chk("R8", "bad wb_en", wb_en, 0);
    chk("R8", "bad addr", mem_addr, 32'h5000);
    apply(enc(0, 1, 1, 0, 1, 0, 4'h6, 12'h0F0), 32'h5000, 0, 0, 0);
    chk("R8", "imm bit4 not bad", bad_enc, 0);
    chk("R8", "imm bit4 wb_en", wb_en, 1);
  endtask

  task automatic t_pc_base;
    apply(enc(0, 1, 1, 0, 1, 1, 4'hF, 12'h010), 32'hDEAD_0000, 0, 32'h0000_0200, 0);
    chk("R9", "pc pre addr", mem_addr, 32'h0000_0218);
    chk("R9", "pc pre wb_en", wb_en, 0);
    apply(enc(0, 0, 1, 0, 0, 1, 4'hF, 12'h010), 32'hDEAD_0000, 0, 32'h0000_0200, 0);
    chk("R9", "pc post addr", mem_addr, 32'h0000_0208);
    chk("R9", "pc post wb_en", wb_en, 0);
  endtask

  task automatic t_passthru;
    apply(enc(0, 1, 1, 1, 0, 1, 4'h2, 12'h0), 32'h0, 0, 0, 0);
    chk("R10", "load byte", {is_load, is_byte}, 2'b11);
    apply(enc(0, 1, 1, 0, 0, 0, 4'h2, 12'h0), 32'h0, 0, 0, 0);
    chk("R10", "store word", {is_load, is_byte}, 2'b00);
  endtask

  initial begin
    t_reset();
    t_post_imm();
    t_pre_modes();
    t_reg_shifts();
    t_zero_amounts();
    t_bad_enc();
    t_pc_base();
    t_passthru();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual running expected done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule